// File: doc/BRIEF.md
# Bit-Serial I2C Service Interface

This block connects a host to an I2C bus one bit at a time. The host runs a short service routine for each bit. The block samples every received bit on the rising edge of SCL and drives the host's transmit bit onto SDA. It raises an attention output whenever the host has work to do. While any status flag is pending, it stretches the SCL low phase, so the bus cannot move ahead of the software.

The host reaches the block through two register slots:

- **Control slot (selector 0).** A read returns the live flags. A write is a set of write-one-to-clear and action bits.
- **Data slot (selector 1).** A read returns the last received bit. A write loads the next bit to send.

A transmit-active gate decides whether the block may pull SDA low at all. Two action commands produce a repeated start and a stop. Each one waits a programmable number of system clocks after SCL has gone high. Both bus lines are modelled as a level input plus a pull-down enable.

Top module: `i2c_bitsvc`

## Requirements
- R1: `attn` is 1 exactly when at least one of `data_rdy`, `arb_lost`, `start_seen` and `stop_seen` is 1.
- R2: SCL and SDA each pass through a two-flop synchronizer. A rising edge of the synchronized SCL sets `data_rdy` on the next clock and captures the synchronized SDA into `rx_bit`.
- R3: `data_rdy` is cleared by a control write with bit 0 set, or by any read or write of the data slot. If a set event and a clear fall in the same cycle, the flag ends up 1.
- R4: While any flag is pending and the synchronized SCL is low, `scl_pull` is 1. It stays 1 until every flag is 0. Clearing `data_rdy` alone does not release SCL while another flag remains.
- R5: `xmit_act` is set by a data write or by a repeated-start or stop command. It is cleared by a data read or a control write with bit 4 set. It is also forced to 0 in the cycle `arb_lost` is set, and that clear wins over every set.
- R6: `sda_pull` is 1 only while `xmit_act` is 1. In plain bit mode it is then the inverse of the last data bit written (`wr_data[0]`).
- R7: `arb_lost` is set on a synchronized SCL rising edge when `xmit_act` is 1, the block is releasing SDA, and SDA reads 0.
- R8: `start_seen` is set when the synchronized SDA falls while the synchronized SCL is high. `stop_seen` is set when SDA rises while SCL is high.
- R9: A control write with bit 5 set releases SDA. Once synchronized SCL has been high for SETUP_CYC clocks, the block pulls SDA low and holds it there until the next data write or command. This forms a repeated start.
- R10: A control write with bit 6 set pulls SDA low. Once synchronized SCL has been high for SETUP_CYC clocks, the block releases SDA. This forms a stop.
- R11: Control-write bits 1, 2 and 3 clear `arb_lost`, `start_seen` and `stop_seen`, but never in the same cycle as their own set event. Any control bit written as 0 has no effect.
- R12: `rd_data` is combinational. With selector 0 it returns {2'b0, `xmit_act`, `attn`, `stop_seen`, `start_seen`, `arb_lost`, `data_rdy`}. With selector 1 it returns {7'b0, `rx_bit`}. Command bits therefore read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Level seen on the SCL wire |
| sda_in | input | 1 | Level seen on the SDA wire |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_sel | input | 1 | Slot select: 0 control/status, 1 data |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for the selected slot |
| attn | output | 1 | Host service needed |
| data_rdy | output | 1 | A bit was clocked on SCL |
| arb_lost | output | 1 | Arbitration lost |
| start_seen | output | 1 | Start condition observed |
| stop_seen | output | 1 | Stop condition observed |
| rx_bit | output | 1 | Last sampled SDA bit |
| xmit_act | output | 1 | Transmit gate for SDA |
| scl_pull | output | 1 | Pull SCL low (stretch) |
| sda_pull | output | 1 | Pull SDA low |

## Verification
The interesting collision is a host clear command arriving in the very cycle a bus event sets the same flag. The clear-data-ready write is timed to land on the clock that registers a synchronized SCL rise, and the bench expects `data_rdy` still to be 1. A second collision occurs inside the ARL case, where the arbitration-loss event and the transmit gate meet at one edge. A behavioural model advanced on every clock predicts both outcomes. Every output is compared with that model each cycle, besides the targeted checks.

// File: rtl/i2c_bitsvc_pkg.sv
package i2c_bitsvc_pkg;
  // control-slot write bit positions
  localparam int CMD_CLR_DRDY  = 0;
  localparam int CMD_CLR_ARL   = 1;
  localparam int CMD_CLR_START = 2;
  localparam int CMD_CLR_STOP  = 3;
  localparam int CMD_CLR_XACT  = 4;
  localparam int CMD_RSTART    = 5;
  localparam int CMD_STOP      = 6;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;

  typedef enum logic [1:0] {
    TX_BIT    = 2'd0,
    TX_RSTART = 2'd1,
    TX_STOP   = 2'd2
  } tx_mode_e;
endpackage

// File: rtl/bitsvc_sync.sv
module bitsvc_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  localparam int TOP = STAGES - 1;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // idle bus is high: reset to 1 so release produces no edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], din[i]};
        prev_q  <= chain_q[TOP];
      end
    end

    assign lvl[i]  = chain_q[TOP];
    assign rise[i] = chain_q[TOP] & ~prev_q;
    assign fall[i] = ~chain_q[TOP] & prev_q;
  end
endmodule

// File: rtl/bitsvc_flags.sv
module bitsvc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_drdy,
  input  logic clr_arl,
  input  logic clr_start,
  input  logic clr_stop,
  input  logic clr_xact,
  input  logic xact_set,
  input  logic data_acc,
  input  logic data_rd,
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  input  logic want_low,
  output logic drdy,
  output logic arl,
  output logic strt,
  output logic stp,
  output logic xact,
  output logic rx
);
  logic drdy_q, arl_q, strt_q, stp_q, xact_q, rx_q;
  logic drdy_d, arl_d, strt_d, stp_d, xact_d, rx_d;
  logic arl_set;

  always_comb begin
    arl_set = scl_rise & xact_q & ~want_low & ~sda_lvl;
    // set events take priority over host clears
    drdy_d  = scl_rise | (drdy_q & ~(clr_drdy | data_acc));
    rx_d    = scl_rise ? sda_lvl : rx_q;
    arl_d   = arl_set | (arl_q & ~clr_arl);
    strt_d  = (sda_fall & scl_lvl) | (strt_q & ~clr_start);
    stp_d   = (sda_rise & scl_lvl) | (stp_q & ~clr_stop);
    if (arl_set)                  xact_d = 1'b0;
    else if (xact_set)            xact_d = 1'b1;
    else if (data_rd | clr_xact)  xact_d = 1'b0;
    else                          xact_d = xact_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q <= 1'b0;
      arl_q  <= 1'b0;
      strt_q <= 1'b0;
      stp_q  <= 1'b0;
      xact_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      drdy_q <= drdy_d;
      arl_q  <= arl_d;
      strt_q <= strt_d;
      stp_q  <= stp_d;
      xact_q <= xact_d;
      rx_q   <= rx_d;
    end
  end

  assign drdy = drdy_q;
  assign arl  = arl_q;
  assign strt = strt_q;
  assign stp  = stp_q;
  assign xact = xact_q;
  assign rx   = rx_q;

  AST_DRDY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_q) |-> $past(scl_rise)); // R2
  AST_ARL_DROPS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arl_q) |-> !xact_q); // R5
  AST_ARL_NEEDS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arl_q) |-> $past(xact_q)); // R7
  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strt_q) |-> $past(scl_lvl)); // R8
  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stp_q) |-> $past(scl_lvl)); // R8
endmodule

// File: rtl/bitsvc_drive.sv
module bitsvc_drive
  import i2c_bitsvc_pkg::*;
#(
  parameter int SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic data_bit,
  input  logic go_rstart,
  input  logic go_stop,
  input  logic scl_lvl,
  input  logic xact,
  input  logic pending,
  output logic want_low,
  output logic sda_pull,
  output logic scl_pull
);
  localparam int CNT_W = $clog2(SETUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(SETUP_CYC - 1);

  tx_mode_e         mode_q, mode_d;
  logic             tx_q, tx_d;
  logic             fired_q, fired_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             str_q, str_d;
  logic             new_cmd;

  always_comb begin
    new_cmd = data_wr | go_rstart | go_stop;

    if (go_stop)        mode_d = TX_STOP;
    else if (go_rstart) mode_d = TX_RSTART;
    else if (data_wr)   mode_d = TX_BIT;
    else                mode_d = mode_q;

    tx_d = data_wr ? data_bit : tx_q;

    // high-time counter, saturating
    if (!scl_lvl)              cnt_d = '0;
    else if (cnt_q != CNT_SAT) cnt_d = cnt_q + CNT_W'(1);
    else                       cnt_d = cnt_q;

    if (new_cmd)
      fired_d = 1'b0;
    else if (scl_lvl && cnt_q == CNT_FIRE && mode_q != TX_BIT)
      fired_d = 1'b1;
    else
      fired_d = fired_q;

    str_d = pending & (str_q | ~scl_lvl);

    unique case (mode_q)
      TX_RSTART: want_low = fired_q;
      TX_STOP:   want_low = ~fired_q;
      default:   want_low = ~tx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TX_BIT;
      tx_q    <= 1'b1;
      fired_q <= 1'b0;
      cnt_q   <= '0;
      str_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      tx_q    <= tx_d;
      fired_q <= fired_d;
      cnt_q   <= cnt_d;
      str_q   <= str_d;
    end
  end

  assign sda_pull = xact & want_low;
  assign scl_pull = str_q;

  AST_STRETCH_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> $past(pending)); // R4
  AST_FIRE_IN_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired_q) |-> $past(scl_lvl)); // R9
  AST_NO_STRETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !scl_pull) |=> !scl_pull); // R4
endmodule

// File: rtl/i2c_bitsvc.sv
module i2c_bitsvc
  import i2c_bitsvc_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       attn,
  output logic       data_rdy,
  output logic       arb_lost,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       rx_bit,
  output logic       xmit_act,
  output logic       scl_pull,
  output logic       sda_pull
);
  logic       rst_meta, rst_core_n;
  logic [1:0] l_lvl, l_rise, l_fall;
  logic       ctrl_wr, data_wr, data_rd, want_low;
  logic       unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  bitsvc_sync #(.LINES(2), .STAGES(SYNC_STAGE)) u_sync (
    .clk (clk), .rst_n(rst_core_n),
    .din ({sda_in, scl_in}),
    .lvl (l_lvl), .rise(l_rise), .fall(l_fall)
  );

  assign ctrl_wr     = reg_wr & ~reg_sel;
  assign data_wr     = reg_wr & reg_sel;
  assign data_rd     = reg_rd & reg_sel;
  assign unused_bits = ^{wr_data[7], l_fall[LINE_SCL]};

  bitsvc_flags u_flags (
    .clk      (clk), .rst_n(rst_core_n),
    .clr_drdy (ctrl_wr & wr_data[CMD_CLR_DRDY]),
    .clr_arl  (ctrl_wr & wr_data[CMD_CLR_ARL]),
    .clr_start(ctrl_wr & wr_data[CMD_CLR_START]),
    .clr_stop (ctrl_wr & wr_data[CMD_CLR_STOP]),
    .clr_xact (ctrl_wr & wr_data[CMD_CLR_XACT]),
    .xact_set (data_wr | (ctrl_wr & (wr_data[CMD_RSTART] | wr_data[CMD_STOP]))),
    .data_acc (data_wr | data_rd),
    .data_rd  (data_rd),
    .scl_lvl  (l_lvl[LINE_SCL]),
    .scl_rise (l_rise[LINE_SCL]),
    .sda_lvl  (l_lvl[LINE_SDA]),
    .sda_rise (l_rise[LINE_SDA]),
    .sda_fall (l_fall[LINE_SDA]),
    .want_low (want_low),
    .drdy     (data_rdy), .arl(arb_lost), .strt(start_seen),
    .stp      (stop_seen), .xact(xmit_act), .rx(rx_bit)
  );

  assign attn = data_rdy | arb_lost | start_seen | stop_seen;

  bitsvc_drive #(.SETUP_CYC(SETUP_CYC)) u_drive (
    .clk      (clk), .rst_n(rst_core_n),
    .data_wr  (data_wr),
    .data_bit (wr_data[0]),
    .go_rstart(ctrl_wr & wr_data[CMD_RSTART]),
    .go_stop  (ctrl_wr & wr_data[CMD_STOP]),
    .scl_lvl  (l_lvl[LINE_SCL]),
    .xact     (xmit_act),
    .pending  (attn),
    .want_low (want_low),
    .sda_pull (sda_pull),
    .scl_pull (scl_pull)
  );

  always_comb begin
    if (reg_sel) rd_data = {7'b0, rx_bit};
    else         rd_data = {2'b0, xmit_act, attn, stop_seen, start_seen, arb_lost, data_rdy};
  end

  AST_SDA_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    sda_pull |-> xmit_act); // R6
endmodule

// File: tb/tb_i2c_bitsvc.sv
module tb_i2c_bitsvc;
  localparam int SETUP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_scl = 1'b1, b_oth = 1'b0;
  logic b_wr = 1'b0, b_rd = 1'b0, b_sel = 1'b0;
  logic [7:0] b_wd = 8'h00;
  logic [7:0] rd_data;
  logic attn, data_rdy, arb_lost, start_seen, stop_seen, rx_bit, xmit_act, scl_pull, sda_pull;
  logic scl_line, sda_line;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_line = b_scl & ~scl_pull;
  assign sda_line = ~b_oth & ~sda_pull;

  i2c_bitsvc #(.SETUP_CYC(SETUP)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .reg_wr(b_wr), .reg_rd(b_rd), .reg_sel(b_sel), .wr_data(b_wd),
    .rd_data(rd_data), .attn(attn), .data_rdy(data_rdy), .arb_lost(arb_lost),
    .start_seen(start_seen), .stop_seen(stop_seen), .rx_bit(rx_bit),
    .xmit_act(xmit_act), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  // ---------------- behavioural reference ----------------
  bit ms1, ms2, mps, md1, md2, mpd;
  bit m_drdy, m_arl, m_strt, m_stp, m_xact, m_rx, m_tx, m_fired, m_str;
  int m_mode, m_cnt;
  bit w_want, w_scl, w_sda, w_srise, w_drise, w_dfall, w_pend, w_arl, w_dw, w_dr, w_new;
  bit [7:0] w_c;

  function automatic bit want_of(int mode, bit tx, bit fired);
    if (mode == 1) return fired;
    if (mode == 2) return !fired;
    return !tx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; mps = 1; md1 = 1; md2 = 1; mpd = 1;
      m_drdy = 0; m_arl = 0; m_strt = 0; m_stp = 0; m_xact = 0; m_rx = 0;
      m_tx = 1; m_fired = 0; m_str = 0; m_mode = 0; m_cnt = 0;
    end else begin
      w_want  = want_of(m_mode, m_tx, m_fired);
      w_scl   = b_scl & !m_str;
      w_sda   = !b_oth & !(m_xact & w_want);
      w_srise = ms2 & !mps;
      w_drise = md2 & !mpd;
      w_dfall = !md2 & mpd;
      w_pend  = m_drdy | m_arl | m_strt | m_stp;
      w_c     = (b_wr && !b_sel) ? b_wd : 8'h00;
      w_dw    = b_wr & b_sel;
      w_dr    = b_rd & b_sel;
      w_new   = w_dw | w_c[5] | w_c[6];
      w_arl   = w_srise & m_xact & !w_want & !md2;
      if (w_srise) m_rx = md2;
      m_drdy = w_srise | (m_drdy & !(w_c[0] | w_dw | w_dr));
      m_arl  = w_arl | (m_arl & !w_c[1]);
      m_strt = (w_dfall & ms2) | (m_strt & !w_c[2]);
      m_stp  = (w_drise & ms2) | (m_stp & !w_c[3]);
      if (w_arl) m_xact = 0;
      else if (w_new) m_xact = 1;
      else if (w_dr | w_c[4]) m_xact = 0;
      if (w_new) m_fired = 0;
      else if (ms2 && m_cnt == SETUP - 1 && m_mode != 0) m_fired = 1;
      if (w_c[6]) m_mode = 2; else if (w_c[5]) m_mode = 1; else if (w_dw) m_mode = 0;
      if (w_dw) m_tx = b_wd[0];
      if (!ms2) m_cnt = 0; else if (m_cnt != SETUP) m_cnt++;
      m_str = w_pend & (m_str | !ms2);
      mps = ms2; ms2 = ms1; ms1 = w_scl;
      mpd = md2; md2 = md1; md1 = w_sda;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (data_rdy   !== m_drdy) begin errors++; $display("FAIL R2 data_rdy actual=%0d expected=%0d at %0t", data_rdy, m_drdy, $time); end
      if (rx_bit     !== m_rx)   begin errors++; $display("FAIL R2 rx_bit actual=%0d expected=%0d at %0t", rx_bit, m_rx, $time); end
      if (arb_lost   !== m_arl)  begin errors++; $display("FAIL R7 arb_lost actual=%0d expected=%0d at %0t", arb_lost, m_arl, $time); end
      if (start_seen !== m_strt) begin errors++; $display("FAIL R8 start_seen actual=%0d expected=%0d at %0t", start_seen, m_strt, $time); end
      if (stop_seen  !== m_stp)  begin errors++; $display("FAIL R8 stop_seen actual=%0d expected=%0d at %0t", stop_seen, m_stp, $time); end
      if (xmit_act   !== m_xact) begin errors++; $display("FAIL R5 xmit_act actual=%0d expected=%0d at %0t", xmit_act, m_xact, $time); end
      if (attn !== (m_drdy | m_arl | m_strt | m_stp)) begin errors++; $display("FAIL R1 attn actual=%0d expected=%0d at %0t", attn, m_drdy | m_arl | m_strt | m_stp, $time); end
      if (sda_pull !== (m_xact & want_of(m_mode, m_tx, m_fired))) begin errors++; $display("FAIL R6 sda_pull actual=%0d expected=%0d at %0t", sda_pull, m_xact & want_of(m_mode, m_tx, m_fired), $time); end
      if (scl_pull !== m_str)    begin errors++; $display("FAIL R4 scl_pull actual=%0d expected=%0d at %0t", scl_pull, m_str, $time); end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic host_wr(input bit sel, input logic [7:0] d);
    @(negedge clk); b_wr = 1; b_sel = sel; b_wd = d;
    @(negedge clk); b_wr = 0; b_wd = 8'h00;
    idle(3);
  endtask
  task automatic host_rd(input bit sel);
    @(negedge clk); b_rd = 1; b_sel = sel;
    @(negedge clk); b_rd = 0;
    idle(3);
  endtask
  task automatic scl_to(input bit v);
    @(negedge clk); b_scl = v;
  endtask
  task automatic clock_bit;
    scl_to(1); idle(8); scl_to(0); idle(6);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(6);
    // reset state
    chk(attn == 0 && data_rdy == 0 && xmit_act == 0, "R1 reset flags", attn, 0);
    chk(scl_pull == 0 && sda_pull == 0, "R6 reset pulls", {scl_pull, sda_pull}, 0);
    b_sel = 0; #1;
    chk(rd_data == 8'h00, "R12 reset status read", rd_data, 0);

    // receive a 0 then a 1
    scl_to(0); idle(4);
    b_oth = 1;
    clock_bit();
    chk(data_rdy == 1 && rx_bit == 0, "R2 rx 0", {data_rdy, rx_bit}, 2);
    chk(attn == 1, "R1 attn on drdy", attn, 1);
    chk(scl_pull == 1, "R4 stretch on drdy", scl_pull, 1);
    b_sel = 1; #1;
    chk(rd_data == 8'h00, "R12 data read rx0", rd_data, 0);
    host_rd(1);
    chk(data_rdy == 0 && scl_pull == 0, "R3 data read clears", {data_rdy, scl_pull}, 0);
    b_oth = 0;
    clock_bit();
    chk(rx_bit == 1, "R2 rx 1", rx_bit, 1);
    host_wr(0, 8'h01);
    chk(data_rdy == 0 && scl_pull == 0, "R3 ctrl clear drdy", {data_rdy, scl_pull}, 0);

    // transmit a 0, then a 1
    host_wr(1, 8'h00);
    chk(xmit_act == 1 && sda_pull == 1, "R6 tx 0 pulls", {xmit_act, sda_pull}, 3);
    clock_bit();
    chk(rx_bit == 0 && arb_lost == 0, "R7 no arl own 0", {rx_bit, arb_lost}, 0);
    host_wr(1, 8'h01);
    chk(data_rdy == 0 && sda_pull == 0 && xmit_act == 1, "R5 tx 1 released", {data_rdy, sda_pull, xmit_act}, 1);
    host_wr(0, 8'h10);
    chk(xmit_act == 0, "R5 clear xact cmd", xmit_act, 0);
    host_wr(1, 8'h00);
    host_rd(1);
    chk(xmit_act == 0 && sda_pull == 0, "R5 data read clears xact", {xmit_act, sda_pull}, 0);

    // arbitration loss
    host_wr(1, 8'h01);
    b_oth = 1;
    clock_bit();
    chk(arb_lost == 1 && xmit_act == 0, "R7 arl and R5 xact drop", {arb_lost, xmit_act}, 2);
    b_sel = 0; #1;
    chk(rd_data == 8'h13, "R12 status layout", rd_data, 8'h13);
    host_wr(0, 8'h00);
    chk(arb_lost == 1 && data_rdy == 1, "R11 zero write no effect", {arb_lost, data_rdy}, 3);
    host_wr(0, 8'h01);
    chk(data_rdy == 0 && scl_pull == 1, "R4 held by arl", {data_rdy, scl_pull}, 1);
    host_wr(0, 8'h02);
    chk(arb_lost == 0 && scl_pull == 0, "R11 clear arl releases", {arb_lost, scl_pull}, 0);
    b_oth = 0; idle(4);

    // start and stop from another device
    scl_to(1); idle(6);
    host_wr(0, 8'h01);
    b_oth = 1; idle(6);
    chk(start_seen == 1, "R8 start seen", start_seen, 1);
    b_oth = 0; idle(6);
    chk(stop_seen == 1, "R8 stop seen", stop_seen, 1);
    host_wr(0, 8'h0C);
    chk(start_seen == 0 && stop_seen == 0, "R11 clear start stop", {start_seen, stop_seen}, 0);
    scl_to(0); idle(6);

    // stop command
    host_wr(0, 8'h41);
    chk(xmit_act == 1 && sda_pull == 1, "R10 stop pulls low", {xmit_act, sda_pull}, 3);
    scl_to(1); idle(2);
    chk(sda_pull == 1, "R10 held during setup", sda_pull, 1);
    idle(10);
    chk(sda_pull == 0 && stop_seen == 1, "R10 released and stop seen", {sda_pull, stop_seen}, 1);
    host_wr(0, 8'h09);
    scl_to(0); idle(6);

    // repeated start command
    host_wr(0, 8'h21);
    chk(xmit_act == 1 && sda_pull == 0, "R9 rstart releases", {xmit_act, sda_pull}, 2);
    scl_to(1); idle(2);
    chk(sda_pull == 0, "R9 released during setup", sda_pull, 0);
    idle(10);
    chk(sda_pull == 1 && start_seen == 1, "R9 pulled and start seen", {sda_pull, start_seen}, 3);
    scl_to(0); idle(6);
    chk(scl_pull == 1, "R4 stretch after rstart", scl_pull, 1);
    host_wr(0, 8'h05);
    chk(scl_pull == 0, "R4 release after clears", scl_pull, 0);
    host_wr(0, 8'h10);

    // clear in the same cycle as the SCL rise event
    @(negedge clk); b_scl = 1;
    @(negedge clk);
    @(negedge clk); b_wr = 1; b_sel = 0; b_wd = 8'h01;
    @(negedge clk); b_wr = 0; b_wd = 8'h00;
    chk(data_rdy == 1, "R3 event beats clear", data_rdy, 1);
    host_wr(0, 8'h01);
    chk(data_rdy == 0, "R3 later clear", data_rdy, 0);
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule